// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block gathers the pending flags of a large bank of GPIO pins into a compact summary word. Each summary bit stands for a group of four adjacent pins. Software reads the summary through two 32-bit views. A single level interrupt line to the host latches when any summary bit is set, and stays up until software writes the end-of-interrupt bit. It asserts again right after that write if work is still pending.

A status-blanking window protects software while it changes debounce settings. When blanking is enabled and any pin's debounce configuration is written, status generation stops for all pins. The window lasts a programmed number of slow-clock ticks, and a further write during the window starts the count again. While the window is open, the per-pin interrupt-enable view reads as all zeros. Software can poll that view to learn when the window has closed.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n is set one clock after any of pins 4n, 4n+1, 4n+2 or 4n+3 has its pending input high, provided blanking is not active.
- R2: Only summary bits 0 to 45 carry status. Pins 184 and above never set a summary bit, and bits 46 to 63 read as 0.
- R3: `sum_lo` presents summary bits 31:0. `sum_hi` bit k presents summary bit 32+k.
- R4: A one-cycle pulse on `eoi_wr` drops `irq` at the next clock edge. If any summary bit is still set, `irq` rises again one clock later.
- R5: With `blank_en` high, a `cfg_wr` pulse loads the count from `blank_len`. `blank_active` is high from the next cycle while the count is nonzero, and the count falls by one on each `slow_tick`. When `blank_en` is low, `cfg_wr` has no effect.
- R6: The summary reads as 0 from the cycle after `blank_active` first reads high. It recovers one clock after `blank_active` falls.
- R7: `irq` rises one clock after any summary bit is set. It stays high until an end-of-interrupt write, even when the pending inputs clear.
- R8: A `cfg_wr` while blanking is active reloads the count from `blank_len`, which restarts the window.
- R9: `pin_en_rd` equals `pin_en` while blanking is inactive and reads all zeros while it is active.
- R10: `eoi_rd`, the read-back of the end-of-interrupt bit, is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_pend | input | NUM_PINS | Per-pin pending flags |
| pin_en | input | NUM_PINS | Per-pin interrupt-enable bits |
| cfg_wr | input | 1 | Strobe for a debounce configuration write on any pin |
| blank_en | input | 1 | Master field that enables blanking |
| blank_len | input | LEN_W | Master field giving the blanking length in slow ticks |
| slow_tick | input | 1 | One-cycle slow-clock tick |
| eoi_wr | input | 1 | Write strobe of the end-of-interrupt bit |
| sum_lo | output | 32 | Summary bits 31:0 |
| sum_hi | output | 32 | Summary bits 63:32 |
| irq | output | 1 | Shared interrupt line |
| blank_active | output | 1 | Blanking window open |
| pin_en_rd | output | NUM_PINS | Interrupt-enable view, zero while blanking |
| eoi_rd | output | 1 | End-of-interrupt read-back |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Group and live-bit boundaries.** It sets pins at the edge of each group of four and in the masked pins 184 and up. A design with an off-by-one grouping, or one that lets bit 46 through, would show stray summary bits.
- **End-of-interrupt.** It writes end-of-interrupt both with pending work present and with none. A design that did not drop and re-raise the line would hang the host or lose events.
- **Blanking window.** It counts slow ticks to the exact edge where the window closes, and restarts the window part way through. A wrong reload or an early expiry shows up as a mismatch in `blank_active` and in the summary.
- **Writes while blanking is disabled.** It checks that such writes open no window at all.

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS  = 192,
  parameter int GRP       = 4,
  parameter int LIVE_BITS = 46,
  parameter int LEN_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic                cfg_wr,
  input  logic                blank_en,
  input  logic [LEN_W-1:0]    blank_len,
  input  logic                slow_tick,
  input  logic                eoi_wr,
  output logic [31:0]         sum_lo,
  output logic [31:0]         sum_hi,
  output logic                irq,
  output logic                blank_active,
  output logic [NUM_PINS-1:0] pin_en_rd,
  output logic                eoi_rd
);
  localparam int NUM_GRP = NUM_PINS / GRP;
  localparam int NB = (NUM_GRP < LIVE_BITS) ? NUM_GRP : LIVE_BITS;

  logic [63:0]      grp_or;
  logic [63:0]      sum_q;
  logic [LEN_W-1:0] cnt;
  logic             irq_q;

  for (genvar i = 0; i < 64; i++) begin : g_grp
    if (i < NB) begin : g_live
      assign grp_or[i] = |pin_pend[i*GRP +: GRP];
    end else begin : g_dead
      assign grp_or[i] = 1'b0;
    end
  end

  assign blank_active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cfg_wr && blank_en)          cnt <= blank_len;
      else if (slow_tick && blank_active) cnt <= cnt - 1'b1;
      sum_q <= blank_active ? '0 : grp_or;
      if (eoi_wr)          irq_q <= 1'b0;
      else if (|sum_q)     irq_q <= 1'b1;
    end
  end

  assign sum_lo    = sum_q[31:0];
  assign sum_hi    = sum_q[63:32];
  assign irq       = irq_q;
  assign pin_en_rd = blank_active ? '0 : pin_en;
  assign eoi_rd    = 1'b0;

  p_group_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_active && pin_pend[0]) |=> sum_lo[0]);
  p_eoi_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !irq);
  p_blank_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && blank_en && blank_len != '0) |=> blank_active);
  p_blank_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank_active |=> (sum_lo == '0 && sum_hi == '0));
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi_wr) |=> irq);
  p_en_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_active |-> (pin_en_rd == '0));
  p_eoi_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |-> !eoi_rd);
endmodule

// File: tb/test_gpio_irq_summary.sv
`timescale 1ns/1ps
module test_gpio_irq_summary;
  localparam int NP = 192;
  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pin_pend = '0, pin_en = '0, pin_en_rd;
  logic cfg_wr = 0, blank_en = 0, slow_tick = 0, eoi_wr = 0;
  logic [11:0] blank_len = '0;
  logic [31:0] sum_lo, sum_hi;
  logic irq, blank_active, eoi_rd;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_summary i_gpio_irq_summary (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .pin_en(pin_en),
    .cfg_wr(cfg_wr), .blank_en(blank_en), .blank_len(blank_len),
    .slow_tick(slow_tick), .eoi_wr(eoi_wr), .sum_lo(sum_lo), .sum_hi(sum_hi),
    .irq(irq), .blank_active(blank_active), .pin_en_rd(pin_en_rd), .eoi_rd(eoi_rd));

  function automatic logic [63:0] exp_sum(logic [NP-1:0] p);
    logic [63:0] s = '0;
    for (int n = 0; n < 46; n++)
      s[n] = p[4*n] | p[4*n+1] | p[4*n+2] | p[4*n+3];
    return s;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic tick();
    slow_tick = 1; step(); slow_tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    step(3); rst_n = 1; step();
    chk("reset", {sum_hi, sum_lo, 29'd0, irq, blank_active, eoi_rd}, '0);

    // R1 R2 R3: random pending patterns
    for (int it = 0; it < 30; it++) begin
      pin_pend = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (it % 3 == 0) pin_pend = NP'(1) << ($urandom % NP);
      step();
      chk("R1/R3 summary", {sum_hi, sum_lo}, exp_sum(pin_pend));
    end
    // R2: only masked pins high
    pin_pend = '0; pin_pend[191:184] = 8'hFF; step();
    chk("R2 dead bits", {sum_hi, sum_lo}, '0);
    pin_pend = '0; pin_pend[183] = 1; step();
    chk("R2 bit45", {sum_hi, sum_lo}, 64'd1 << 45);
    // R1 group edges
    pin_pend = '0; pin_pend[7] = 1; pin_pend[128] = 1; step();
    chk("R1 edges", {sum_hi, sum_lo}, (64'd1 << 1) | (64'd1 << 32));

    // R7/R4: irq behaviour
    pin_pend = '0; step(); eoi_wr = 1; step(); eoi_wr = 0; step();
    chk("R4 idle", irq, 0);
    pin_pend[10] = 1; step();
    chk("R7 not yet", irq, 0);
    step(); chk("R7 rise", irq, 1);
    pin_pend = '0; step(3); chk("R7 hold", irq, 1);
    eoi_wr = 1; step(); eoi_wr = 0;
    chk("R4 drop", irq, 0);
    chk("R10 eoi read", eoi_rd, 0);
    step(); chk("R4 stays low", irq, 0);
    pin_pend[20] = 1; step(2); chk("R7 rise2", irq, 1);
    eoi_wr = 1; step(); eoi_wr = 0;
    chk("R4 drop2", irq, 0);
    step(); chk("R4 refire", irq, 1);

    // R5: ignored without enable
    pin_en = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    blank_en = 0; blank_len = 12'd3; cfg_wr = 1; step(); cfg_wr = 0;
    chk("R5 ignored", blank_active, 0);
    step(); chk("R5 ignored sum", {sum_hi, sum_lo}, exp_sum(pin_pend));
    chk("R9 visible", pin_en_rd, pin_en);

    // R5 R6 R9: blanking window of 3 ticks
    blank_en = 1; cfg_wr = 1; step(); cfg_wr = 0;
    chk("R5 open", blank_active, 1);
    chk("R9 masked", pin_en_rd, '0);
    step(); chk("R6 blanked", {sum_hi, sum_lo}, '0);
    tick(); tick();
    chk("R5 still open", blank_active, 1);
    // R8: restart
    cfg_wr = 1; step(); cfg_wr = 0;
    tick(); tick();
    chk("R8 restarted", blank_active, 1);
    tick();
    chk("R5 closed", blank_active, 0);
    chk("R9 back", pin_en_rd, pin_en);
    step(); chk("R6 recovered", {sum_hi, sum_lo}, exp_sum(pin_pend));
    blank_len = '0; cfg_wr = 1; step(); cfg_wr = 0;
    chk("R5 zero len", blank_active, 0);
    chk("R10 final", eoi_rd, 0);
    finish_run();
  end
endmodule